// File: doc/BRIEF.md
# PWM Converter Fault Supervisor

This block watches one channel of a switching converter and decides, one PWM period at a time, how the gate drivers react to faults. Three digital comparator results come in: an overcurrent flag that counts only while the high-side switch is on, an undervoltage flag and an overvoltage flag. A one-clock strobe marks the end of each PWM period. Each fault has its own run counter of consecutive faulty periods, and each counter has its own response.

An overcurrent cuts the current high-side pulse short. If it happens in 32 periods in a row, the channel is latched off with both drivers tri-stated. Overvoltage counts only once soft-start has completed. It holds the low-side switch on, and after 32 periods in a row it also latches the channel off, without asking for the soft-start capacitor to be discharged. Undervoltage in 8 periods in a row produces a single-clock hiccup request, which discharges the soft-start capacitor and starts a new soft-start. A latched channel recovers only when its enable input is pulled low, or on power-on reset.

Top module: `pwm_fault_supervisor`

## Requirements
- R1: While `rst` is high, and on the first clock after it, every output is 0.
- R2: A clock edge that sees `hs_on` and `oc_trip` both high, with no `cycle_end`, makes `hg_kill` high from the next clock. It stays high until the clock after the next `cycle_end`.
- R3: A PWM period counts as an overcurrent period if `hs_on && oc_trip` was seen in any clock of it, up to and including its `cycle_end` clock. After 32 such periods in a row, `gate_tristate` and `fault_latched` go high on the clock after the 32nd `cycle_end`. A period without overcurrent restarts the count.
- R4: Overcurrent termination and counting work the same whether `ss_done` is 0 or 1.
- R5: After 8 `cycle_end` strobes in a row that see `uv_trip` high, `ss_discharge` is high for exactly one clock, starting on the clock after the 8th strobe. The undervoltage count then starts again from zero.
- R6: While `ss_done` is 0, `ov_trip` has no effect: `lg_force` stays 0 and those periods add nothing to the overvoltage count.
- R7: With `ss_done` high, `ov_trip` high at a clock edge drives `lg_force` and `hg_kill` high on the next clock, for as long as it persists.
- R8: After 32 `cycle_end` strobes in a row that see `ss_done && ov_trip`, the channel latches off as in R3, and `ss_discharge` stays 0.
- R9: While latched, `gate_tristate` and `fault_latched` are 1 and `hg_kill`, `lg_force` and `ss_discharge` are 0, whatever the fault inputs do.
- R10: `ss_en` low at a clock edge clears the latch and all three counters. All outputs are 0 on the next clock.
- R11: If a latch and a hiccup would happen at the same strobe, the latch wins and no `ss_discharge` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ss_en | input | 1 | Channel enable; low forces a restart and clears a latched fault |
| ss_done | input | 1 | Soft-start has finished |
| cycle_end | input | 1 | One-clock strobe at the end of each PWM period |
| hs_on | input | 1 | High-side switch is on |
| oc_trip | input | 1 | Overcurrent comparator result |
| uv_trip | input | 1 | Feedback-below-undervoltage-threshold comparator result |
| ov_trip | input | 1 | Feedback-above-overvoltage-threshold comparator result |
| hg_kill | output | 1 | Terminate the high-side gate pulse |
| lg_force | output | 1 | Hold the low-side gate on |
| gate_tristate | output | 1 | Put both gate drivers in tri-state |
| ss_discharge | output | 1 | One-clock hiccup request to discharge the soft-start capacitor |
| fault_latched | output | 1 | Channel is latched off |

## Verification
Each fault is driven in runs that stop one period short of its limit, then broken by a clean period and driven again. This separates a consecutive count from a cumulative one and shows exactly where each threshold sits. Overvoltage is applied with soft-start both incomplete and complete, which shows whether the enable is gated correctly. Overcurrent is driven with soft-start incomplete, to show that it is not gated. Overvoltage and undervoltage runs are aligned so that both hit their limits on the same strobe, which exposes the priority between latch and hiccup. Fault activity during a latch and an enable-low restart show what latched state holds and that it clears.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  // Registered drive requests toward the gate driver stage
  typedef struct packed {
    logic kill;
    logic low;
    logic tri_st;
    logic dis;
  } pfs_drive_t;
endpackage

// File: rtl/pfs_run_counter.sv
// Counts consecutive strobes with the fault present; hit fires on the strobe
// that completes RUN of them, and the count restarts after the hit.
module pfs_run_counter #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic strobe,
  input  logic fault,
  output logic hit
);
  localparam int W = $clog2(RUN + 1);
  localparam logic [W-1:0] LAST = W'(RUN - 1);

  logic [W-1:0] cnt;

  assign hit = strobe && fault && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (strobe) begin
      if (!fault || hit) cnt <= '0;
      else               cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pfs_gate_ctrl.sv
// Latch state and registered gate requests with priority latch > OV > OC.
module pfs_gate_ctrl
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       cycle_end,
  input  logic       oc_now,
  input  logic       ov_now,
  input  logic       oc_hit,
  input  logic       ov_hit,
  input  logic       uv_hit,
  output logic       latched,
  output logic       oc_cyc,
  output pfs_drive_t drv
);
  logic latched_q, ocf_q, lgf_q, dis_q;
  logic latch_set;

  assign latch_set = !latched_q && (oc_hit || ov_hit);
  assign oc_cyc    = ocf_q || oc_now;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      latched_q <= 1'b0;
      ocf_q     <= 1'b0;
      lgf_q     <= 1'b0;
      dis_q     <= 1'b0;
    end else if (latched_q || latch_set) begin
      latched_q <= 1'b1;
      ocf_q     <= 1'b0;
      lgf_q     <= 1'b0;
      dis_q     <= 1'b0;
    end else begin
      ocf_q <= cycle_end ? 1'b0 : (ocf_q || oc_now);
      lgf_q <= ov_now;
      dis_q <= uv_hit;
    end
  end

  assign latched    = latched_q;
  assign drv.kill   = ocf_q || lgf_q;
  assign drv.low    = lgf_q;
  assign drv.tri_st = latched_q;
  assign drv.dis    = dis_q;
endmodule

// File: rtl/pwm_fault_supervisor.sv
module pwm_fault_supervisor
  import pfs_pkg::*;
#(
  parameter int OC_RUN = 32,
  parameter int UV_RUN = 8,
  parameter int OV_RUN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic ss_en,
  input  logic ss_done,
  input  logic cycle_end,
  input  logic hs_on,
  input  logic oc_trip,
  input  logic uv_trip,
  input  logic ov_trip,
  output logic hg_kill,
  output logic lg_force,
  output logic gate_tristate,
  output logic ss_discharge,
  output logic fault_latched
);
  logic       oc_now, ov_now, oc_cyc, latched, cnt_clr;
  logic       oc_hit, uv_hit, ov_hit;
  pfs_drive_t drv;

  assign oc_now  = hs_on && oc_trip;
  assign ov_now  = ss_done && ov_trip;
  assign cnt_clr = !ss_en || latched;

  pfs_run_counter #(.RUN(OC_RUN)) u_oc_run (
    .clk(clk), .rst(rst), .clr(cnt_clr), .strobe(cycle_end),
    .fault(oc_cyc), .hit(oc_hit)
  );

  pfs_run_counter #(.RUN(UV_RUN)) u_uv_run (
    .clk(clk), .rst(rst), .clr(cnt_clr), .strobe(cycle_end),
    .fault(uv_trip), .hit(uv_hit)
  );

  pfs_run_counter #(.RUN(OV_RUN)) u_ov_run (
    .clk(clk), .rst(rst), .clr(cnt_clr), .strobe(cycle_end),
    .fault(ov_now), .hit(ov_hit)
  );

  pfs_gate_ctrl u_gate (
    .clk(clk), .rst(rst), .en(ss_en), .cycle_end(cycle_end),
    .oc_now(oc_now), .ov_now(ov_now), .oc_hit(oc_hit), .ov_hit(ov_hit),
    .uv_hit(uv_hit), .latched(latched), .oc_cyc(oc_cyc), .drv(drv)
  );

  assign hg_kill       = drv.kill;
  assign lg_force      = drv.low;
  assign gate_tristate = drv.tri_st;
  assign ss_discharge  = drv.dis;
  assign fault_latched = latched;
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker (
  input logic clk,
  input logic rst,
  input logic ss_en,
  input logic ss_done,
  input logic cycle_end,
  input logic hs_on,
  input logic oc_trip,
  input logic uv_trip,
  input logic ov_trip,
  input logic hg_kill,
  input logic lg_force,
  input logic gate_tristate,
  input logic ss_discharge,
  input logic fault_latched
);
  p_oc_kill_r2: assert property (@(posedge clk) disable iff (rst)
    (ss_en && !gate_tristate && hs_on && oc_trip && !cycle_end) |=> hg_kill);

  p_kill_release_r2: assert property (@(posedge clk) disable iff (rst)
    (cycle_end && !(ss_done && ov_trip)) |=> !hg_kill);

  p_hiccup_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ss_discharge |=> !ss_discharge);

  p_ov_gated_r6: assert property (@(posedge clk) disable iff (rst)
    !ss_done |=> !lg_force);

  p_ov_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ss_en && !gate_tristate && ss_done && ov_trip && !cycle_end) |=> (lg_force && hg_kill));

  p_latch_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    gate_tristate |-> (fault_latched && !hg_kill && !lg_force && !ss_discharge));

  p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (gate_tristate && ss_en) |=> gate_tristate);

  p_restart_r10: assert property (@(posedge clk) disable iff (rst)
    !ss_en |=> (!gate_tristate && !hg_kill && !lg_force && !ss_discharge));
endmodule

bind pwm_fault_supervisor pfs_checker u_chk (.*);

// File: tb/pwm_fault_supervisor_bench.sv
`timescale 1ns/100ps
module pwm_fault_supervisor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ss_en = 1'b1, ss_done = 1'b0, cycle_end = 1'b0;
  logic hs_on = 1'b0, oc_trip = 1'b0, uv_trip = 1'b0, ov_trip = 1'b0;
  logic hg_kill, lg_force, gate_tristate, ss_discharge, fault_latched;

  int n_tests = 0;
  int n_fail  = 0;
  int n_clk   = 0;

  always #2.5 clk = ~clk;

  pwm_fault_supervisor u_pwm_fault_supervisor (
    .clk(clk), .rst(rst), .ss_en(ss_en), .ss_done(ss_done),
    .cycle_end(cycle_end), .hs_on(hs_on), .oc_trip(oc_trip),
    .uv_trip(uv_trip), .ov_trip(ov_trip), .hg_kill(hg_kill),
    .lg_force(lg_force), .gate_tristate(gate_tristate),
    .ss_discharge(ss_discharge), .fault_latched(fault_latched)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, updated at every rising edge
  int  m_oc = 0, m_uv = 0, m_ov = 0;
  bit  m_lat = 0, m_ocf = 0, m_lgf = 0, m_dis = 0;

  always @(posedge clk) begin
    bit occ, hic, lset;
    if (rst || !ss_en) begin
      m_oc = 0; m_uv = 0; m_ov = 0;
      m_lat = 0; m_ocf = 0; m_lgf = 0; m_dis = 0;
    end else if (m_lat) begin
      m_ocf = 0; m_lgf = 0; m_dis = 0;
    end else begin
      hic = 0; lset = 0;
      occ = m_ocf || (hs_on && oc_trip);
      if (cycle_end) begin
        m_oc = occ ? m_oc + 1 : 0;
        m_ov = (ss_done && ov_trip) ? m_ov + 1 : 0;
        m_uv = uv_trip ? m_uv + 1 : 0;
        if (m_oc == 32 || m_ov == 32) lset = 1;
        if (m_uv == 8) begin hic = 1; m_uv = 0; end
      end
      if (lset) begin
        m_lat = 1; m_oc = 0; m_uv = 0; m_ov = 0;
        m_ocf = 0; m_lgf = 0; m_dis = 0;
      end else begin
        m_ocf = cycle_end ? 0 : occ;
        m_lgf = ss_done && ov_trip;
        m_dis = hic;
      end
    end
  end

  always @(negedge clk) begin
    check("R2 hg_kill vs model", hg_kill, m_ocf || m_lgf);
    check("R7 lg_force vs model", lg_force, m_lgf);
    check("R5 ss_discharge vs model", ss_discharge, m_dis);
    check("R9 gate_tristate vs model", gate_tristate, m_lat);
    check("R3 fault_latched vs model", fault_latched, m_lat);
  end

  always @(posedge clk) begin
    n_clk++;
    if (n_clk > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    hs_on = 0; oc_trip = 0; uv_trip = 0; ov_trip = 0; cycle_end = 0;
  endtask

  // One 4-clock PWM period; cycle_end sits on its last clock
  task automatic pwm_cyc(input bit oc, input bit uv, input bit ov);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      hs_on = (k < 2); oc_trip = oc && (k == 1);
      uv_trip = uv; ov_trip = ov; cycle_end = (k == 3);
    end
  endtask

  task automatic run(input int n, input bit oc, input bit uv, input bit ov);
    for (int i = 0; i < n; i++) pwm_cyc(oc, uv, ov);
    idle();
  endtask

  task automatic restart();
    @(negedge clk); ss_en = 0; hs_on = 0; oc_trip = 0; uv_trip = 0; ov_trip = 0; cycle_end = 0;
    @(negedge clk); ss_en = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset hg_kill", hg_kill, 1'b0);
    check("R1 reset gate_tristate", gate_tristate, 1'b0);
    rst = 0;
    @(negedge clk);
    check("R1 after reset ss_discharge", ss_discharge, 1'b0);

    // R2: immediate termination, released at strobe
    hs_on = 1; oc_trip = 1;
    @(negedge clk);
    check("R2 kill after oc", hg_kill, 1'b1);
    oc_trip = 0;
    @(negedge clk);
    check("R2 kill held", hg_kill, 1'b1);
    cycle_end = 1; hs_on = 0;
    idle();
    check("R2 kill released at strobe", hg_kill, 1'b0);
    run(1, 0, 0, 0);

    // R3/R4: consecutive overcurrent with ss_done low
    run(31, 1, 0, 0);
    check("R3 no latch at 31", fault_latched, 1'b0);
    run(1, 0, 0, 0);
    run(31, 1, 0, 0);
    check("R3 clean period restarted count", fault_latched, 1'b0);
    run(1, 1, 0, 0);
    check("R3 latch at 32", fault_latched, 1'b1);
    check("R4 oc counts during soft-start", gate_tristate, 1'b1);

    // R9: inputs ignored while latched
    ss_done = 1;
    run(10, 1, 1, 1);
    check("R9 still latched", gate_tristate, 1'b1);
    check("R9 no low force", lg_force, 1'b0);
    check("R9 no hiccup", ss_discharge, 1'b0);

    // R10: restart clears latch and counters
    restart();
    check("R10 latch cleared", fault_latched, 1'b0);
    run(31, 1, 0, 0);
    check("R10 counter cleared", fault_latched, 1'b0);
    run(1, 0, 0, 0);

    // R5: undervoltage hiccup
    run(7, 0, 1, 0);
    check("R5 no hiccup at 7", ss_discharge, 1'b0);
    pwm_cyc(0, 1, 0);
    idle();
    check("R5 hiccup pulse", ss_discharge, 1'b1);
    idle();
    check("R5 hiccup one clock", ss_discharge, 1'b0);
    run(7, 0, 1, 0);
    check("R5 count restarted", ss_discharge, 1'b0);
    run(1, 0, 0, 0);

    // R6: overvoltage ignored before soft-start completes
    ss_done = 0;
    run(40, 0, 0, 1);
    check("R6 no latch", fault_latched, 1'b0);
    check("R6 no low force", lg_force, 1'b0);

    // R7: low-side forced
    ss_done = 1;
    @(negedge clk); ov_trip = 1;
    @(negedge clk);
    check("R7 lg_force", lg_force, 1'b1);
    check("R7 hg_kill with ov", hg_kill, 1'b1);
    idle();

    // R8: overvoltage latch without discharge
    run(31, 0, 0, 1);
    check("R8 no latch at 31", fault_latched, 1'b0);
    run(1, 0, 0, 1);
    check("R8 latch at 32", gate_tristate, 1'b1);
    check("R8 no discharge", ss_discharge, 1'b0);

    // R11: latch beats a simultaneous hiccup
    restart();
    run(24, 0, 0, 1);
    run(8, 0, 1, 1);
    check("R11 latched", fault_latched, 1'b1);
    check("R11 hiccup suppressed", ss_discharge, 1'b0);
    restart();
    run(2, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule